// File: doc/BRIEF.md
# Memory Write Error Injection Unit

This unit sits beside the write path of a memory controller and deliberately corrupts selected writes so that error detection and reporting can be exercised. A write is corrupted only when its decoded location (module, rank, bank, page and column) matches a programmed address pattern. The corruption is applied in one of two ways. An ECC flip mask can be XORed into the write's check bits, or a parity-flip flag can be raised for the address-parity logic downstream. Either or both can be requested.

Software programs four registers through a simple write port: the address-match word, a per-field wildcard word, the ECC flip mask and the control word. Setting either request bit in the control word arms the unit and takes a snapshot of the match, wildcard and mask settings. Writing any of those three registers afterwards disarms the unit, so changed settings take effect only when the control word arms it again.

Injection can be one-shot or repeating, and it can be restricted to the lower or upper 32-byte half of a cache line. The layout of the module and rank fields in the match word depends on whether more than two modules are populated.

Top module: `mem_err_inject`

## Requirements
- R1: After reset, all four registers read back as zero, `injArmed` is 0 and `outValid` is 0.
- R2: With `multiModule`=0 the match word holds the column in bits 13:0, the page in 29:14, the bank in 33:30, the rank (2 bits) in 35:34 and the module bit 0 in bit 36. A write fires only when every non-wildcard field is equal.
- R3: With `multiModule`=1 the module (2 bits) is compared against match bits 36:35, and rank bit 0 is compared against bit 34.
- R4: Wildcard register bits remove fields from the comparison: bit 0 column, bit 1 page, bit 2 bank, bit 3 rank, bit 4 module.
- R5: A request with `wrIsWrite`=0 (a read) never fires. Its check bits pass through unchanged and `outParityFlip` stays 0.
- R6: Control bits 2:1 select the cache-line halves. Bit 1 enables the lower half (`wrUpperHalf`=0) and bit 2 enables the upper half. With 00, nothing fires.
- R7: On a firing write with control bit 3 set, `outEcc` is the input check bits XOR the armed mask. With control bit 4 set, `outParityFlip` is 1. On a non-firing write, `outEcc` equals the input and `outParityFlip` is 0.
- R8: With control bit 0 (repeat) clear, only the first matching write fires, and the unit then clears control bits 4:3.
- R9: With repeat set, every matching write fires until the control word is rewritten without request bits.
- R10: Writing the match (register 0), wildcard (1) or mask (2) register clears control bits 4:3. The new values are used only after the next arming write to control (register 3).
- R11: `cfgRdata` returns the register selected by `cfgAddr`, zero-extended. `injArmed` is 1 exactly when control bit 3 or bit 4 is set.
- R12: Outputs are registered: `outValid`, `outEcc` and `outParityFlip` reflect the request presented one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 2 | Register select: 0 match, 1 wildcard, 2 mask, 3 control |
| cfgWdata | input | CFG_W (37) | Register write data |
| cfgRdata | output | CFG_W (37) | Read-back of the selected register |
| injArmed | output | 1 | Injection armed (control bit 3 or 4 set) |
| multiModule | input | 1 | More than two modules populated; selects the module/rank field layout |
| wrValid | input | 1 | Request valid |
| wrIsWrite | input | 1 | 1 for a write, 0 for a read |
| wrUpperHalf | input | 1 | 1 when the data is the upper 32-byte half of the cache line |
| wrModule | input | 2 | Module number |
| wrRank | input | 2 | Rank number |
| wrBank | input | 4 | Bank number |
| wrPage | input | 16 | Page (row) address |
| wrCol | input | 14 | Column address |
| wrEcc | input | ECC_W (32) | Check bits from the encoder |
| outValid | output | 1 | Registered request valid |
| outEcc | output | ECC_W (32) | Check bits, possibly flipped |
| outParityFlip | output | 1 | Request to invert the address parity |

## Verification
Faults in the control and snapshot state show at the ports on the next write:
- A stale snapshot or a wrong field slice flips check bits on a location that should not match, or fails to flip them on one that should. This appears in `outEcc` one cycle after the request.
- A one-shot that fails to disarm shows as a second corrupted write, and also as `injArmed` still high.
- A missed disarm after a parameter write shows as corruption on a write that follows the register write.
- Each of these faults appears within one or two requests of its cause.

The bench sweeps every module and rank value under both field layouts. For each request it compares `outEcc` with a value it computes itself.

// File: rtl/wi_pkg.sv
package wi_pkg;
  // Field layout of the address-match word; neighbours decode these positions.
  localparam int COL_LO  = 0;
  localparam int COL_W   = 14;
  localparam int PAGE_LO = COL_LO + COL_W;
  localparam int PAGE_W  = 16;
  localparam int BANK_LO = PAGE_LO + PAGE_W;
  localparam int BANK_W  = 4;
  localparam int RANK_LO = BANK_LO + BANK_W;
  localparam int MOD_HI  = RANK_LO + 2;
  localparam int MATCH_W = MOD_HI + 1;

  // Control word bits
  localparam int CTRL_W    = 5;
  localparam int CB_REPEAT = 0;
  localparam int CB_LOWER  = 1;
  localparam int CB_UPPER  = 2;
  localparam int CB_ECC    = 3;
  localparam int CB_PAR    = 4;

  // Wildcard word bits
  localparam int ANY_W   = 5;
  localparam int AB_COL  = 0;
  localparam int AB_PAGE = 1;
  localparam int AB_BANK = 2;
  localparam int AB_RANK = 3;
  localparam int AB_MOD  = 4;

  typedef enum logic [1:0] {
    REG_MATCH = 2'd0,
    REG_ANY   = 2'd1,
    REG_MASK  = 2'd2,
    REG_CTRL  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic loadActive;
    logic fire;
    logic flipEcc;
    logic flipParity;
  } injStrobe_t;
endpackage

// File: rtl/wi_ctrl.sv
module wi_ctrl
  import wi_pkg::*;
#(
  parameter int ECC_W = 32,
  localparam int CFG_W = (ECC_W > MATCH_W) ? ECC_W : MATCH_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [1:0]         cfgAddr,
  input  logic [CFG_W-1:0]   cfgWdata,
  output logic [CFG_W-1:0]   cfgRdata,
  output logic               injArmed,
  input  logic               wrValid,
  input  logic               wrIsWrite,
  input  logic               wrUpperHalf,
  input  logic               matchHit,
  output logic [MATCH_W-1:0] matchReg,
  output logic [ANY_W-1:0]   anyReg,
  output logic [ECC_W-1:0]   maskReg,
  output injStrobe_t         strb
);
  logic [CTRL_W-1:0] ctrlReg;
  logic halfOk;
  logic fire;
  regSel_e sel;

  assign sel      = regSel_e'(cfgAddr);
  assign injArmed = ctrlReg[CB_ECC] | ctrlReg[CB_PAR];
  assign halfOk   = wrUpperHalf ? ctrlReg[CB_UPPER] : ctrlReg[CB_LOWER];
  assign fire     = injArmed && wrValid && wrIsWrite && matchHit && halfOk;

  always_comb begin
    strb.fire       = fire;
    strb.flipEcc    = fire & ctrlReg[CB_ECC];
    strb.flipParity = fire & ctrlReg[CB_PAR];
    strb.loadActive = cfgWe && (sel == REG_CTRL) &&
                      (cfgWdata[CB_ECC] | cfgWdata[CB_PAR]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchReg <= '0;
      anyReg   <= '0;
      maskReg  <= '0;
      ctrlReg  <= '0;
    end else if (cfgWe) begin
      case (sel)
        REG_MATCH: begin
          matchReg <= cfgWdata[MATCH_W-1:0];
          ctrlReg[CB_PAR:CB_ECC] <= 2'b00;
        end
        REG_ANY: begin
          anyReg <= cfgWdata[ANY_W-1:0];
          ctrlReg[CB_PAR:CB_ECC] <= 2'b00;
        end
        REG_MASK: begin
          maskReg <= cfgWdata[ECC_W-1:0];
          ctrlReg[CB_PAR:CB_ECC] <= 2'b00;
        end
        default: ctrlReg <= cfgWdata[CTRL_W-1:0];
      endcase
    end else if (fire && !ctrlReg[CB_REPEAT]) begin
      ctrlReg[CB_PAR:CB_ECC] <= 2'b00;
    end
  end

  always_comb begin
    case (sel)
      REG_MATCH: cfgRdata = CFG_W'(matchReg);
      REG_ANY:   cfgRdata = CFG_W'(anyReg);
      REG_MASK:  cfgRdata = CFG_W'(maskReg);
      default:   cfgRdata = CFG_W'(ctrlReg);
    endcase
  end
endmodule

// File: rtl/wi_datapath.sv
module wi_datapath
  import wi_pkg::*;
#(
  parameter int ECC_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  injStrobe_t         strb,
  input  logic [MATCH_W-1:0] matchReg,
  input  logic [ANY_W-1:0]   anyReg,
  input  logic [ECC_W-1:0]   maskReg,
  input  logic               multiModule,
  input  logic               wrValid,
  input  logic [1:0]         wrModule,
  input  logic [1:0]         wrRank,
  input  logic [BANK_W-1:0]  wrBank,
  input  logic [PAGE_W-1:0]  wrPage,
  input  logic [COL_W-1:0]   wrCol,
  input  logic [ECC_W-1:0]   wrEcc,
  output logic               matchHit,
  output logic               outValid,
  output logic [ECC_W-1:0]   outEcc,
  output logic               outParityFlip
);
  logic [MATCH_W-1:0] actMatch;
  logic [ANY_W-1:0]   actAny;
  logic [ECC_W-1:0]   actMask;
  logic colHit, pageHit, bankHit, rankHit, modHit;

  // Snapshot taken only when the control word arms injection.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      actMatch <= '0;
      actAny   <= '0;
      actMask  <= '0;
    end else if (strb.loadActive) begin
      actMatch <= matchReg;
      actAny   <= anyReg;
      actMask  <= maskReg;
    end
  end

  always_comb begin
    colHit  = actAny[AB_COL]  || (wrCol  == actMatch[COL_LO +: COL_W]);
    pageHit = actAny[AB_PAGE] || (wrPage == actMatch[PAGE_LO +: PAGE_W]);
    bankHit = actAny[AB_BANK] || (wrBank == actMatch[BANK_LO +: BANK_W]);
    if (multiModule) begin
      modHit  = wrModule == actMatch[MOD_HI -: 2];
      rankHit = wrRank[0] == actMatch[RANK_LO];
    end else begin
      modHit  = wrModule[0] == actMatch[MOD_HI];
      rankHit = wrRank == actMatch[RANK_LO +: 2];
    end
    modHit   = modHit  || actAny[AB_MOD];
    rankHit  = rankHit || actAny[AB_RANK];
    matchHit = colHit && pageHit && bankHit && rankHit && modHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid      <= 1'b0;
      outEcc        <= '0;
      outParityFlip <= 1'b0;
    end else begin
      outValid      <= wrValid;
      outEcc        <= wrEcc ^ (strb.flipEcc ? actMask : '0);
      outParityFlip <= strb.flipParity;
    end
  end
endmodule

// File: rtl/mem_err_inject.sv
module mem_err_inject
  import wi_pkg::*;
#(
  parameter int ECC_W = 32,
  localparam int CFG_W = (ECC_W > MATCH_W) ? ECC_W : MATCH_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgAddr,
  input  logic [CFG_W-1:0]  cfgWdata,
  output logic [CFG_W-1:0]  cfgRdata,
  output logic              injArmed,
  input  logic              multiModule,
  input  logic              wrValid,
  input  logic              wrIsWrite,
  input  logic              wrUpperHalf,
  input  logic [1:0]        wrModule,
  input  logic [1:0]        wrRank,
  input  logic [BANK_W-1:0] wrBank,
  input  logic [PAGE_W-1:0] wrPage,
  input  logic [COL_W-1:0]  wrCol,
  input  logic [ECC_W-1:0]  wrEcc,
  output logic              outValid,
  output logic [ECC_W-1:0]  outEcc,
  output logic              outParityFlip
);
  injStrobe_t         strb;
  logic               matchHit;
  logic [MATCH_W-1:0] matchReg;
  logic [ANY_W-1:0]   anyReg;
  logic [ECC_W-1:0]   maskReg;

  wi_ctrl #(.ECC_W(ECC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .injArmed(injArmed),
    .wrValid(wrValid), .wrIsWrite(wrIsWrite), .wrUpperHalf(wrUpperHalf),
    .matchHit(matchHit), .matchReg(matchReg), .anyReg(anyReg),
    .maskReg(maskReg), .strb(strb)
  );

  wi_datapath #(.ECC_W(ECC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .matchReg(matchReg),
    .anyReg(anyReg), .maskReg(maskReg), .multiModule(multiModule),
    .wrValid(wrValid), .wrModule(wrModule), .wrRank(wrRank),
    .wrBank(wrBank), .wrPage(wrPage), .wrCol(wrCol), .wrEcc(wrEcc),
    .matchHit(matchHit), .outValid(outValid), .outEcc(outEcc),
    .outParityFlip(outParityFlip)
  );
endmodule

// File: rtl/mem_err_inject_chk.sv
module mem_err_inject_chk
  import wi_pkg::*;
#(
  parameter int ECC_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWe,
  input logic [1:0]       cfgAddr,
  input logic             injArmed,
  input logic             wrValid,
  input logic             wrIsWrite,
  input logic [ECC_W-1:0] wrEcc,
  input logic             outValid,
  input logic [ECC_W-1:0] outEcc,
  input logic             outParityFlip,
  input injStrobe_t       strb
);
  // R5: a read never alters check bits or parity
  a_r5_read_untouched: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrIsWrite) |=> (outEcc == $past(wrEcc) && !outParityFlip));

  // R7: without a firing strobe the outputs carry the request unchanged
  a_r7_no_fire_passthru: assert property (@(posedge clk) disable iff (!rstN)
    !strb.fire |=> (outEcc == $past(wrEcc) && !outParityFlip));

  // R8: firing needs the unit to be armed
  a_r8_fire_needs_arm: assert property (@(posedge clk) disable iff (!rstN)
    strb.fire |-> injArmed);

  // R10: a parameter register write leaves the unit disarmed
  a_r10_param_disarms: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgAddr != 2'd3) |=> !injArmed);

  // R12: one-cycle registered valid
  a_r12_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |=> outValid);
  a_r12_idle_follows: assert property (@(posedge clk) disable iff (!rstN)
    !wrValid |=> !outValid);
endmodule

bind mem_err_inject mem_err_inject_chk #(.ECC_W(ECC_W)) u_chk (.*);

// File: tb/mem_err_inject_bench.sv
module mem_err_inject_bench;
  localparam int ECC_W = 32;
  localparam int CFG_W = 37;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [1:0] cfgAddr = 2'd0;
  logic [CFG_W-1:0] cfgWdata = '0;
  logic [CFG_W-1:0] cfgRdata;
  logic injArmed;
  logic multiModule = 1'b0;
  logic wrValid = 1'b0, wrIsWrite = 1'b0, wrUpperHalf = 1'b0;
  logic [1:0] wrModule = '0, wrRank = '0;
  logic [3:0] wrBank = '0;
  logic [15:0] wrPage = '0;
  logic [13:0] wrCol = '0;
  logic [ECC_W-1:0] wrEcc = '0;
  logic outValid;
  logic [ECC_W-1:0] outEcc;
  logic outParityFlip;

  int total = 0, passed = 0;
  logic [ECC_W-1:0] gotEcc;
  logic gotPar, gotValid;

  always #2 clk = ~clk;

  mem_err_inject u_mem_err_inject (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act === exp) passed++;
    else $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
  endtask

  task automatic cfgWrite(input logic [1:0] a, input logic [CFG_W-1:0] d);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(posedge clk); @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic cfgRead(input logic [1:0] a, output logic [CFG_W-1:0] d);
    cfgAddr = a; #1; d = cfgRdata;
  endtask

  task automatic req(input logic [1:0] m, r, input logic [3:0] b,
                     input logic [15:0] p, input logic [13:0] c,
                     input logic isW, up, input logic [ECC_W-1:0] e);
    wrValid = 1'b1; wrIsWrite = isW; wrUpperHalf = up;
    wrModule = m; wrRank = r; wrBank = b; wrPage = p; wrCol = c; wrEcc = e;
    @(posedge clk); @(negedge clk);
    gotEcc = outEcc; gotPar = outParityFlip; gotValid = outValid;
    wrValid = 1'b0;
  endtask

  function automatic logic [36:0] mkWord(input logic multi, input logic [1:0] m, r,
      input logic [3:0] b, input logic [15:0] p, input logic [13:0] c);
    return multi ? {m, r[0], b, p, c} : {m[0], r, b, p, c};
  endfunction

  localparam logic [3:0]  B0 = 4'd5;
  localparam logic [15:0] P0 = 16'hBEEF;
  localparam logic [13:0] C0 = 14'h123;
  localparam logic [31:0] MASKA = 32'h0000_0101;
  localparam logic [31:0] MASKB = 32'h0300_0000;

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

  initial begin
    logic [CFG_W-1:0] rd;
    logic [31:0] e;
    logic hit;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 armed", 64'(injArmed), 0);
    chk("R1 outValid", 64'(outValid), 0);
    for (int a = 0; a < 4; a++) begin
      cfgRead(2'(a), rd);
      chk("R1 reg", 64'(rd), 0);
    end

    // R2 low layout sweep, repeat + both halves + ECC
    cfgWrite(2'd0, CFG_W'(mkWord(1'b0, 2'd1, 2'd2, B0, P0, C0)));
    cfgWrite(2'd1, '0);
    cfgWrite(2'd2, CFG_W'(MASKA));
    cfgWrite(2'd3, CFG_W'(5'b01111));
    cfgRead(2'd3, rd);
    chk("R11 ctrl readback", 64'(rd), 64'h0F);
    chk("R11 armed", 64'(injArmed), 1);
    for (int m = 0; m < 4; m++)
      for (int r = 0; r < 4; r++) begin
        e = 32'hA5A5_0000 + 32'(m * 16 + r);
        hit = (m % 2 == 1) && (r == 2);
        req(2'(m), 2'(r), B0, P0, C0, 1'b1, 1'b0, e);
        chk("R2 low sweep ecc", 64'(gotEcc), 64'(hit ? e ^ MASKA : e));
        chk("R7 no parity", 64'(gotPar), 0);
      end
    req(2'd1, 2'd2, B0, P0, C0 + 14'd1, 1'b1, 1'b0, 32'h1);
    chk("R2 column miss", 64'(gotEcc), 64'h1);
    req(2'd1, 2'd2, B0, P0 ^ 16'h8000, C0, 1'b1, 1'b0, 32'h2);
    chk("R2 page miss", 64'(gotEcc), 64'h2);
    req(2'd1, 2'd2, B0 ^ 4'h8, P0, C0, 1'b1, 1'b0, 32'h3);
    chk("R2 bank miss", 64'(gotEcc), 64'h3);

    // R5 reads do not fire
    req(2'd1, 2'd2, B0, P0, C0, 1'b0, 1'b0, 32'h44);
    chk("R5 read ecc", 64'(gotEcc), 64'h44);
    chk("R5 read parity", 64'(gotPar), 0);

    // R6 half select
    cfgWrite(2'd3, CFG_W'(5'b01011));
    req(2'd1, 2'd2, B0, P0, C0, 1'b1, 1'b1, 32'h10);
    chk("R6 upper blocked", 64'(gotEcc), 64'h10);
    req(2'd1, 2'd2, B0, P0, C0, 1'b1, 1'b0, 32'h10);
    chk("R6 lower fires", 64'(gotEcc), 64'(32'h10 ^ MASKA));
    cfgWrite(2'd3, CFG_W'(5'b01101));
    req(2'd1, 2'd2, B0, P0, C0, 1'b1, 1'b0, 32'h20);
    chk("R6 lower blocked", 64'(gotEcc), 64'h20);
    req(2'd1, 2'd2, B0, P0, C0, 1'b1, 1'b1, 32'h20);
    chk("R6 upper fires", 64'(gotEcc), 64'(32'h20 ^ MASKA));
    cfgWrite(2'd3, CFG_W'(5'b01001));
    req(2'd1, 2'd2, B0, P0, C0, 1'b1, 1'b0, 32'h30);
    chk("R6 none selected", 64'(gotEcc), 64'h30);

    // R4 wildcards
    cfgWrite(2'd1, CFG_W'(5'b11111));
    chk("R10 wildcard write disarms", 64'(injArmed), 0);
    cfgWrite(2'd3, CFG_W'(5'b01111));
    req(2'd2, 2'd1, 4'd9, 16'h0001, 14'h3FFF, 1'b1, 1'b0, 32'h55);
    chk("R4 all any", 64'(gotEcc), 64'(32'h55 ^ MASKA));
    cfgWrite(2'd1, CFG_W'(5'b00001));
    cfgWrite(2'd3, CFG_W'(5'b01111));
    req(2'd1, 2'd2, B0, P0, 14'h0777, 1'b1, 1'b0, 32'h66);
    chk("R4 column any", 64'(gotEcc), 64'(32'h66 ^ MASKA));
    req(2'd1, 2'd2, B0, 16'h0000, 14'h0777, 1'b1, 1'b0, 32'h66);
    chk("R4 page still compared", 64'(gotEcc), 64'h66);

    // R3 high layout sweep
    multiModule = 1'b1;
    cfgWrite(2'd1, '0);
    cfgWrite(2'd0, CFG_W'(mkWord(1'b1, 2'd2, 2'd1, B0, P0, C0)));
    cfgWrite(2'd3, CFG_W'(5'b01111));
    for (int m = 0; m < 4; m++)
      for (int r = 0; r < 4; r++) begin
        e = 32'h5A00_0000 + 32'(m * 16 + r);
        hit = (m == 2) && (r % 2 == 1);
        req(2'(m), 2'(r), B0, P0, C0, 1'b1, 1'b1, e);
        chk("R3 high sweep ecc", 64'(gotEcc), 64'(hit ? e ^ MASKA : e));
      end

    // R8 one-shot parity
    cfgWrite(2'd3, CFG_W'(5'b10110));
    req(2'd2, 2'd1, B0, P0, C0, 1'b1, 1'b0, 32'h77);
    chk("R8 first parity", 64'(gotPar), 1);
    chk("R7 parity only ecc", 64'(gotEcc), 64'h77);
    chk("R8 disarmed", 64'(injArmed), 0);
    cfgRead(2'd3, rd);
    chk("R8 ctrl readback", 64'(rd), 64'h06);
    req(2'd2, 2'd1, B0, P0, C0, 1'b1, 1'b0, 32'h77);
    chk("R8 second parity", 64'(gotPar), 0);

    // R9 repeat with both flips
    cfgWrite(2'd3, CFG_W'(5'b11111));
    for (int i = 0; i < 3; i++) begin
      req(2'd2, 2'd3, B0, P0, C0, 1'b1, 1'b0, 32'(i));
      chk("R9 repeat parity", 64'(gotPar), 1);
      chk("R9 repeat ecc", 64'(gotEcc), 64'(32'(i) ^ MASKA));
    end
    cfgWrite(2'd3, '0);
    req(2'd2, 2'd3, B0, P0, C0, 1'b1, 1'b0, 32'h9);
    chk("R9 cleared", 64'(gotPar), 0);

    // R10 mask write disarms, applies on re-arm
    cfgWrite(2'd3, CFG_W'(5'b01111));
    cfgWrite(2'd2, CFG_W'(MASKB));
    chk("R10 mask write disarms", 64'(injArmed), 0);
    req(2'd2, 2'd1, B0, P0, C0, 1'b1, 1'b0, 32'hF0);
    chk("R10 no fire after disarm", 64'(gotEcc), 64'hF0);
    cfgRead(2'd2, rd);
    chk("R11 mask readback", 64'(rd), 64'(MASKB));
    cfgWrite(2'd3, CFG_W'(5'b01111));
    req(2'd2, 2'd1, B0, P0, C0, 1'b1, 1'b0, 32'hF0);
    chk("R10 new mask used", 64'(gotEcc), 64'(32'hF0 ^ MASKB));

    // R12 latency
    chk("R12 valid after request", 64'(gotValid), 1);
    @(negedge clk);
    chk("R12 idle", 64'(outValid), 0);

    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end
endmodule